// File: doc/BRIEF.md
# Dual-Mode Serial DAC Input Interface

This block is the digital input stage of a 16-bit DAC. It turns serial data into the parallel code that drives the converter. All of its logic runs on one system clock. The three external pins (serial clock, serial data and latch) pass through a two-stage synchronizer, and their edges are detected on that system clock.

The block has two operating modes. In shift mode, a host clocks bits into a shift register on rising serial-clock edges and then raises the latch line to copy the register into the DAC code. The last bit of the register appears on a serial output pin, so several devices can be chained into one long register.

In frame mode, the latch line is left high. The serial-clock pin then carries a sampling clock at sixteen times the bit rate. The block receives framed words on the data pin and loads the DAC code by itself once a frame is valid. The mode is chosen once after reset from the level of the latch line, and it holds until the next reset.

Top module: `dual_serial_dac_if`

## Requirements
- R1: While and after reset, `dac_code_o` is 0, `load_o` is 0 and `data_out_o` is 0.
- R2: In shift mode, each rising edge of `ser_clk_i` shifts `ser_data_i` into bit 0 of the 16-bit register, so a word sent MSB first ends up in its natural order. A rising edge of `latch_i` copies the register to `dac_code_o` and raises `load_o` for exactly one clock.
- R3: `dac_code_o` never changes, and `load_o` stays low, while bits are shifted in without a latch edge.
- R4: `data_out_o` equals bit 15 of the shift register. It is updated only when a falling edge of `ser_clk_i` is detected.
- R5: With two devices chained from `data_out_o` to `ser_data_i` and sharing a latch, 32 shifted bits put the leading 16 in the far device and the trailing 16 in the near device.
- R6: If `latch_i` is low after reset, the block enters shift mode. If `latch_i` stays high for 288 rising edges of `ser_clk_i` (16 × 18), the block enters frame mode. The mode chosen is kept until reset, and latch edges have no effect in frame mode.
- R7: In frame mode, a frame is one low start bit, 16 data bits MSB first and one high stop bit, each bit lasting 16 ticks. A tick is a rising edge of `ser_clk_i`. The tick on which the line is first seen low is tick 0, and every bit is sampled on tick 8 of its own 16. A valid frame loads `dac_code_o` with the word and pulses `load_o` once, with no latch activity.
- R8: A low pulse on the data line that has ended by tick 8 of the start bit is ignored.
- R9: A frame whose stop bit samples low is discarded, and `dac_code_o` is unchanged. The next valid frame is received normally.
- R10: No frame is accepted while the mode is still undecided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Shift clock in shift mode; 16x sampling clock in frame mode |
| ser_data_i | input | 1 | Serial data in |
| latch_i | input | 1 | Latch request in shift mode; held high to select frame mode |
| dac_code_o | output | 16 | Parallel DAC code |
| load_o | output | 1 | One-clock pulse when the DAC code is updated |
| data_out_o | output | 1 | Serial data out for chaining |

## Verification
Shift mode is exercised with all-zero and all-one words, a walking one across every bit position, and a set of arithmetic mixes. Each word is checked before the latch and again after it. This separates a shift of the wrong direction, a load that happens too early and a wrong output bit, because the serial output is compared after every bit. A 32-bit chain with distinct leading and trailing words shows which device receives which half. In frame mode the same word sweep runs through the receiver. Start glitches, a low stop bit, latch pulses after the mode is decided, and a frame sent before the mode is decided must all leave the code untouched.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    MODE_UNDEC = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_FRAME = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sdac_sync_edge.sv
module sdac_sync_edge #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], async_i};
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sdac_mode_sel.sv
module sdac_mode_sel
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 288
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  latch_lvl_i,
  output mode_e mode_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_TICKS + 1);

  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_UNDEC;
      cnt_q  <= '0;
    end else if (mode_q == MODE_UNDEC) begin
      if (!latch_lvl_i) begin
        mode_q <= MODE_SHIFT;
      end else if (tick_i) begin
        if (cnt_q == CNT_W'(FRAME_TICKS - 1)) mode_q <= MODE_FRAME;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mode_o = mode_q;

  // R6
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_UNDEC) |=> $stable(mode_q));
endmodule

// File: rtl/sdac_shift_port.sv
module sdac_shift_port #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clk_rise_i,
  input  logic          clk_fall_i,
  input  logic          data_i,
  input  logic          latch_rise_i,
  output logic [DW-1:0] word_o,
  output logic          take_o,
  output logic          dout_o
);
  logic [DW-1:0] sr_q;
  logic          dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else if (en_i) begin
      if (clk_rise_i) sr_q <= {sr_q[DW-2:0], data_i};
      // next device samples on its rising edge, so change on the fall
      if (clk_fall_i) dout_q <= sr_q[DW-1];
    end
  end

  assign word_o = sr_q;
  assign take_o = en_i & latch_rise_i;
  assign dout_o = dout_q;

  // R4
  dout_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_fall_i |=> $stable(dout_q));
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          line_i,
  output logic [DW-1:0] word_o,
  output logic          take_o
);
  // OVS must be a power of two: the tick counter wraps per bit
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned BW  = $clog2(DW);
  localparam int unsigned MID = OVS / 2;

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sr_q;
  logic          sample;

  assign sample = tick_i && (state_q != RX_IDLE) && (cnt_q == CW'(MID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sr_q    <= '0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
    end else if (tick_i) begin
      if (state_q == RX_IDLE) begin
        if (!line_i) begin
          state_q <= RX_START;
          cnt_q   <= CW'(1);
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (sample) begin
          unique case (state_q)
            RX_START: begin
              if (line_i) state_q <= RX_IDLE;
              else begin
                state_q <= RX_DATA;
                bit_q   <= '0;
              end
            end
            RX_DATA: begin
              sr_q <= {sr_q[DW-2:0], line_i};
              if (bit_q == BW'(DW - 1)) state_q <= RX_STOP;
              else bit_q <= bit_q + 1'b1;
            end
            default: state_q <= RX_IDLE;
          endcase
        end
      end
    end
  end

  assign word_o = sr_q;
  assign take_o = sample && (state_q == RX_STOP) && line_i;

  // R7
  stop_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample && state_q == RX_STOP) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/dual_serial_dac_if.sv
module dual_serial_dac_if
  import sdac_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned OVS = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ser_clk_i,
  input  logic          ser_data_i,
  input  logic          latch_i,
  output logic [DW-1:0] dac_code_o,
  output logic          load_o,
  output logic          data_out_o
);
  localparam int unsigned FRAME_TICKS = OVS * (DW + 2);
  // bit order {latch, data, clk}; latch and data idle high
  localparam logic [2:0] PIN_RST = 3'b110;

  logic [2:0]    pin_lvl, pin_rise, pin_fall;
  mode_e         mode;
  logic [DW-1:0] sh_word, rx_word;
  logic          sh_take, rx_take;
  logic [DW-1:0] dac_q;
  logic          load_q;

  sdac_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({latch_i, ser_data_i, ser_clk_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  sdac_mode_sel #(.FRAME_TICKS(FRAME_TICKS)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (pin_rise[0]),
    .latch_lvl_i(pin_lvl[2]),
    .mode_o     (mode)
  );

  sdac_shift_port #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (mode == MODE_SHIFT),
    .clk_rise_i  (pin_rise[0]),
    .clk_fall_i  (pin_fall[0]),
    .data_i      (pin_lvl[1]),
    .latch_rise_i(pin_rise[2]),
    .word_o      (sh_word),
    .take_o      (sh_take),
    .dout_o      (data_out_o)
  );

  sdac_frame_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mode == MODE_FRAME),
    .tick_i(pin_rise[0]),
    .line_i(pin_lvl[1]),
    .word_o(rx_word),
    .take_o(rx_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= sh_take | rx_take;
      if (sh_take) dac_q <= sh_word;
      else if (rx_take) dac_q <= rx_word;
    end
  end

  assign dac_code_o = dac_q;
  assign load_o     = load_q;

  // R2
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q);

  // R3
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |-> $stable(dac_q));

  // R10
  load_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> ($past(mode) != MODE_UNDEC));
endmodule

// File: tb/dual_serial_dac_if_test.sv
`timescale 1ns/100ps
module dual_serial_dac_if_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic man_clk = 1'b0, osc_clk = 1'b0, osc_run = 1'b0;
  logic [1:0] osc_div = '0;
  logic shift_mode = 1'b1;
  logic ser_data = 1'b0, latch = 1'b0;
  logic ser_clk;
  logic [15:0] dac, dac2;
  logic load, load2, dout, dout2;
  int total = 0, bad = 0, load_cnt = 0;
  logic [15:0] m_sr = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (osc_run) begin
      if (osc_div == 2'd1) begin
        osc_clk <= ~osc_clk;
        osc_div <= '0;
      end else osc_div <= osc_div + 1'b1;
    end

  assign ser_clk = shift_mode ? man_clk : osc_clk;

  dual_serial_dac_if uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .latch_i(latch), .dac_code_o(dac), .load_o(load), .data_out_o(dout));

  dual_serial_dac_if uut2 (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(ser_clk), .ser_data_i(dout),
    .latch_i(latch), .dac_code_o(dac2), .load_o(load2), .data_out_o(dout2));

  always @(negedge clk) if (rst_n && load) load_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #20;
    rst_n = 1'b1;
    #20;
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    #20 man_clk = 1'b1;
    #20 man_clk = 1'b0;
    #20;
    m_sr = {m_sr[14:0], b};
    chk("R4 dout", {31'd0, dout}, {31'd0, m_sr[15]});
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_latch();
    #20 latch = 1'b1;
    #20 latch = 1'b0;
    #40;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge osc_clk);
    #1;
  endtask

  task automatic send_frame(input logic [15:0] w, input logic stop);
    @(posedge osc_clk);
    #1;
    ser_data = 1'b0;
    ticks(16);
    for (int i = 15; i >= 0; i--) begin
      ser_data = w[i];
      ticks(16);
    end
    ser_data = stop;
    ticks(16);
    ser_data = 1'b1;
    ticks(24);
  endtask

  task automatic shift_case(input logic [15:0] w);
    logic [15:0] prev;
    int c0;
    prev = dac;
    c0 = load_cnt;
    shift_word(w);
    chk("R3 dac held", {16'd0, dac}, {16'd0, prev});
    chk("R3 no load", load_cnt, c0);
    pulse_latch();
    chk("R2 dac", {16'd0, dac}, {16'd0, w});
    chk("R2 load", load_cnt, c0 + 1);
  endtask

  task automatic frame_case(input logic [15:0] w);
    int c0;
    c0 = load_cnt;
    send_frame(w, 1'b1);
    chk("R7 dac", {16'd0, dac}, {16'd0, w});
    chk("R7 load", load_cnt, c0 + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    int c0;
    // shift mode
    #1;
    do_reset();
    chk("R1 dac", {16'd0, dac}, 32'd0);
    chk("R1 load", {31'd0, load}, 32'd0);
    chk("R1 dout", {31'd0, dout}, 32'd0);
    shift_case(16'h0000);
    shift_case(16'hFFFF);
    for (int i = 0; i < 16; i++) shift_case(16'h0001 << i);
    for (int i = 1; i <= 8; i++) shift_case(16'(i * 16'h3B5D) ^ 16'hC3A1);
    // R5 chain
    shift_word(16'h9C31);
    shift_word(16'h47E5);
    pulse_latch();
    chk("R5 near", {16'd0, dac}, 32'h47E5);
    chk("R5 far", {16'd0, dac2}, 32'h9C31);
    // R6 long latch high keeps shift mode
    c0 = load_cnt;
    keep = m_sr;
    latch = 1'b1;
    #40;
    for (int i = 0; i < 300; i++) shift_bit(1'b1);
    latch = 1'b0;
    #40;
    chk("R6 latch snapshot", {16'd0, dac}, {16'd0, keep});
    chk("R6 one load", load_cnt, c0 + 1);
    shift_case(16'h5AC3);

    // frame mode
    shift_mode = 1'b0;
    latch = 1'b1;
    ser_data = 1'b1;
    osc_run = 1'b1;
    do_reset();
    m_sr = '0;
    c0 = load_cnt;
    send_frame(16'h1234, 1'b1);
    ticks(40);
    chk("R10 no early frame", {16'd0, dac}, 32'd0);
    chk("R10 no load", load_cnt, c0);
    frame_case(16'h0000);
    frame_case(16'hFFFF);
    for (int i = 0; i < 16; i++) frame_case(16'h8000 >> i);
    for (int i = 1; i <= 4; i++) frame_case(16'(i * 16'h2F1B) ^ 16'h6D09);
    // R8 start glitches
    keep = dac;
    c0 = load_cnt;
    @(posedge osc_clk);
    #1 ser_data = 1'b0;
    ticks(4);
    ser_data = 1'b1;
    ticks(40);
    ser_data = 1'b0;
    ticks(7);
    ser_data = 1'b1;
    ticks(40);
    chk("R8 glitch dac", {16'd0, dac}, {16'd0, keep});
    chk("R8 glitch load", load_cnt, c0);
    frame_case(16'hA55A);
    // R9 low stop
    keep = dac;
    c0 = load_cnt;
    send_frame(16'h0F0F, 1'b0);
    ticks(40);
    chk("R9 bad stop dac", {16'd0, dac}, {16'd0, keep});
    chk("R9 bad stop load", load_cnt, c0);
    frame_case(16'hC0DE);
    // R6 latch ignored in frame mode
    keep = dac;
    c0 = load_cnt;
    latch = 1'b0;
    #40 latch = 1'b1;
    #80;
    chk("R6 latch ignored dac", {16'd0, dac}, {16'd0, keep});
    chk("R6 latch ignored load", load_cnt, c0);
    frame_case(16'h7E81);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule